// File: doc/BRIEF.md
# Overcurrent Alarm Conditioner

This block sits between an external overcurrent alarm pin and the rest of a power-management path. The pin is asynchronous to the core clock. The block applies a programmable polarity and synchronizes the pin through two flops. It then counts each new alarm assertion in a saturating event counter. A sticky interrupt is raised once the count reaches a programmed threshold. If the alarm stays quiet for a programmed number of clocks, the count is cleared, and the quiet filter is ready again for the next burst.

A throttle request follows the synchronized alarm. After the alarm goes away, the request stays high for a hold time given in microseconds. A clocks-per-microsecond prescaler converts that hold time into clocks. The hold is a three-state machine:

- **IDLE**: no request.
- **ACTIVE**: the alarm is present.
- **HOLD**: the alarm has gone and the hold timer is running.

The transitions are:

- *engage* (IDLE to ACTIVE): the alarm appears.
- *linger* (ACTIVE to HOLD): the alarm goes away and the hold time is non-zero.
- *drop* (ACTIVE to IDLE): the alarm goes away and the hold time is zero.
- *re-engage* (HOLD to ACTIVE): the alarm returns before the timer expires.
- *expire* (HOLD to IDLE): the timer runs out.

The throttle request is high in ACTIVE and in HOLD. Arbitration of the request against other throttle sources is done elsewhere.

Top module: `ocp_alarm_cond`

## Requirements
- R1: With `cfg_active_low`=1 a low pin level is the alarm and a high level is idle; with `cfg_active_low`=0 a high level is the alarm.
- R2: Each inactive-to-active change of the synchronized alarm adds one to `event_count`. The new value is visible after the third rising clock edge that follows the pin change.
- R3: `event_count` saturates at 2^CNT_W-1 and never wraps.
- R4: With `cfg_irq_en`=1, `irq` is set by an event whose new count is greater than or equal to `cfg_irq_thresh`. With a threshold of 0 (or 1), every event sets it.
- R5: With `cfg_irq_en`=0, `irq` is never set, whatever the count.
- R6: `irq` stays set until a one-cycle `irq_clear` pulse. The clear leaves `event_count` unchanged. If an event sets `irq` in the same cycle as the clear, the set wins.
- R7: With `cfg_quiet_clks`=Q>0, `event_count` is cleared after Q consecutive clocks with the synchronized alarm inactive. It is 0 after Q+2 edges from the pin deassertion and still non-zero after Q+1 edges. Q=0 disables clearing.
- R8: `throttle_req` rises on the third clock edge after the pin asserts (the engage transition).
- R9: After the pin deasserts, `throttle_req` is still high after 2+H·C edges and low after 3+H·C edges. H is `cfg_hold_us`; C is `cfg_clks_per_us`, with 0 treated as 1. H=0 releases the request at once (the drop transition).
- R10: An alarm that returns during HOLD keeps `throttle_req` high for as long as it lasts; the hold time then restarts in full from the next deassertion.
- R11: During and right after reset, `throttle_req`, `irq` and `event_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_pin | input | 1 | Raw asynchronous overcurrent alarm |
| cfg_active_low | input | 1 | 1: alarm is asserted low |
| cfg_irq_en | input | 1 | Enables the count-threshold interrupt |
| cfg_irq_thresh | input | CNT_W | Event count that sets the interrupt |
| cfg_quiet_clks | input | FILT_W | Quiet clocks before the count clears; 0 disables |
| cfg_hold_us | input | HOLD_W | Throttle hold time in microseconds |
| cfg_clks_per_us | input | PRE_W | Clocks per microsecond (0 treated as 1) |
| irq_clear | input | 1 | One-cycle pulse that clears the interrupt |
| throttle_req | output | 1 | Throttle request |
| irq | output | 1 | Sticky interrupt flag |
| event_count | output | CNT_W | Current alarm event count |

## Verification
The bench sweeps every combination of hold time and prescaler in a small range. It samples the request exactly one edge before and one edge at its computed release. A timer that is off by one, or that ignores a prescaler of 0, fails there.

It sweeps the interrupt threshold from 0 upward, pulse by pulse. A comparator that used equality, or that treated a threshold of 0 as "never", would set the flag on the wrong pulse.

Quiet-filter boundaries, saturation past the maximum count, a clear that collides with an event, and an alarm that returns during HOLD are each driven directly. A wrapping counter, a clear that loses an event, or a HOLD state that ignores the alarm would each show up at the ports.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } hold_state_e;
endpackage

// File: rtl/ocp_alarm_sync.sv
module ocp_alarm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_pin,
    input  logic cfg_active_low,
    output logic level,
    output logic rise
);
    logic corrected;
    logic meta_q, sync_q, prev_q;

    assign corrected = alarm_pin ^ cfg_active_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= corrected;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
endmodule

// File: rtl/ocp_event_counter.sv
module ocp_event_counter #(
    parameter int CNT_W  = 4,
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic              rise,
    input  logic [FILT_W-1:0] cfg_quiet_clks,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_irq_thresh,
    input  logic              irq_clear,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
    localparam logic [FILT_W-1:0] Q_ONE   = FILT_W'(1);

    logic [FILT_W-1:0] quiet_q;
    logic [FILT_W-1:0] quiet_nxt;
    logic [CNT_W-1:0]  cnt_inc;
    logic              quiet_done;

    assign cnt_inc    = (count == CNT_MAX) ? CNT_MAX : count + CNT_ONE;
    assign quiet_nxt  = quiet_q + Q_ONE;
    assign quiet_done = (cfg_quiet_clks != '0) && (count != '0) && !level
                        && (quiet_nxt == cfg_quiet_clks);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            quiet_q <= '0;
        end else if (rise) begin
            count   <= cnt_inc;
            quiet_q <= '0;
        end else if (level || count == '0 || cfg_quiet_clks == '0) begin
            quiet_q <= '0;
        end else if (quiet_done) begin
            count   <= '0;
            quiet_q <= '0;
        end else begin
            quiet_q <= quiet_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (rise && cfg_irq_en && (cnt_inc >= cfg_irq_thresh)) begin
            irq <= 1'b1;
        end else if (irq_clear) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/ocp_throttle_hold.sv
module ocp_throttle_hold
    import ocp_pkg::*;
#(
    parameter int HOLD_W = 4,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic [PRE_W-1:0]  cfg_clks_per_us,
    output logic              throttle_req
);
    localparam logic [PRE_W-1:0]  P_ONE = PRE_W'(1);
    localparam logic [HOLD_W-1:0] H_ONE = HOLD_W'(1);

    hold_state_e       state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic [HOLD_W-1:0] us_q;
    logic [PRE_W-1:0]  pre_last;
    logic              us_tick, hold_done;

    assign pre_last  = (cfg_clks_per_us == '0) ? '0 : cfg_clks_per_us - P_ONE;
    assign us_tick   = (pre_q == pre_last);
    assign hold_done = us_tick && (us_q == cfg_hold_us - H_ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (level) state_d = ST_ACTIVE;
            ST_ACTIVE: if (!level) state_d = (cfg_hold_us == '0) ? ST_IDLE : ST_HOLD;
            ST_HOLD: begin
                if (level)          state_d = ST_ACTIVE;
                else if (hold_done) state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (state_q != ST_HOLD) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (us_tick) begin
            pre_q <= '0;
            us_q  <= us_q + H_ONE;
        end else begin
            pre_q <= pre_q + P_ONE;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ACTIVE, ST_HOLD: throttle_req = 1'b1;
            default:            throttle_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ocp_alarm_cond.sv
module ocp_alarm_cond #(
    parameter int CNT_W  = 4,
    parameter int FILT_W = 8,
    parameter int HOLD_W = 4,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_pin,
    input  logic              cfg_active_low,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_irq_thresh,
    input  logic [FILT_W-1:0] cfg_quiet_clks,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic [PRE_W-1:0]  cfg_clks_per_us,
    input  logic              irq_clear,
    output logic              throttle_req,
    output logic              irq,
    output logic [CNT_W-1:0]  event_count
);
    logic level, rise;

    ocp_alarm_sync u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .alarm_pin      (alarm_pin),
        .cfg_active_low (cfg_active_low),
        .level          (level),
        .rise           (rise)
    );

    ocp_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .level          (level),
        .rise           (rise),
        .cfg_quiet_clks (cfg_quiet_clks),
        .cfg_irq_en     (cfg_irq_en),
        .cfg_irq_thresh (cfg_irq_thresh),
        .irq_clear      (irq_clear),
        .count          (event_count),
        .irq            (irq)
    );

    ocp_throttle_hold #(.HOLD_W(HOLD_W), .PRE_W(PRE_W)) u_hold (
        .clk             (clk),
        .rst_n           (rst_n),
        .level           (level),
        .cfg_hold_us     (cfg_hold_us),
        .cfg_clks_per_us (cfg_clks_per_us),
        .throttle_req    (throttle_req)
    );
endmodule

// File: rtl/ocp_alarm_cond_chk.sv
module ocp_alarm_cond_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_irq_en,
    input logic             irq_clear,
    input logic             irq,
    input logic             throttle_req,
    input logic [CNT_W-1:0] event_count
);
    localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (event_count != $past(event_count)) |->
        (event_count == '0 || {1'b0, event_count} == {1'b0, $past(event_count)} + 1'b1));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, $past(event_count)} == MAX_EXT && event_count != '0) |->
        ({1'b0, event_count} == MAX_EXT));

    a_r5_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg_irq_en));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    a_r8_event_engages: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, event_count} == {1'b0, $past(event_count)} + 1'b1) |-> throttle_req);
endmodule

bind ocp_alarm_cond ocp_alarm_cond_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_irq_en   (cfg_irq_en),
    .irq_clear    (irq_clear),
    .irq          (irq),
    .throttle_req (throttle_req),
    .event_count  (event_count)
);

// File: tb/test_ocp_alarm_cond.sv
`timescale 1ns/1ps
module test_ocp_alarm_cond;
    localparam int CNT_W = 4, FILT_W = 8, HOLD_W = 4, PRE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alarm_pin = 1'b0;
    logic              cfg_active_low = 1'b0;
    logic              cfg_irq_en = 1'b0;
    logic [CNT_W-1:0]  cfg_irq_thresh = '0;
    logic [FILT_W-1:0] cfg_quiet_clks = '0;
    logic [HOLD_W-1:0] cfg_hold_us = '0;
    logic [PRE_W-1:0]  cfg_clks_per_us = '0;
    logic              irq_clear = 1'b0;
    logic              throttle_req, irq;
    logic [CNT_W-1:0]  event_count;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ocp_alarm_cond #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W), .PRE_W(PRE_W))
    i_ocp_alarm_cond (
        .clk(clk), .rst_n(rst_n), .alarm_pin(alarm_pin),
        .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
        .cfg_irq_thresh(cfg_irq_thresh), .cfg_quiet_clks(cfg_quiet_clks),
        .cfg_hold_us(cfg_hold_us), .cfg_clks_per_us(cfg_clks_per_us),
        .irq_clear(irq_clear), .throttle_req(throttle_req), .irq(irq),
        .event_count(event_count)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_alarm(input bit active);
        alarm_pin = active ^ cfg_active_low;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_alarm(1'b0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic pulse();
        set_alarm(1'b1);
        wait_n(2);
        set_alarm(1'b0);
        wait_n(3);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R11: reset state
        check("R11 throttle", throttle_req, 0);
        check("R11 irq", irq, 0);
        check("R11 count", event_count, 0);
        do_reset();
        check("R11 count after release", event_count, 0);

        // R2 / R8: exact latency of count and request
        set_alarm(1'b1);
        wait_n(2);
        check("R2 count before third edge", event_count, 0);
        check("R8 throttle before third edge", throttle_req, 0);
        wait_n(1);
        check("R2 count at third edge", event_count, 1);
        check("R8 throttle at third edge", throttle_req, 1);
        set_alarm(1'b0);
        wait_n(4);

        // R9: hold sweep over hold time and prescaler
        for (int h = 0; h < 4; h++) begin
            for (int c = 0; c < 4; c++) begin
                int ceff;
                int hc;
                ceff = (c == 0) ? 1 : c;
                hc = h * ceff;
                cfg_hold_us = HOLD_W'(h);
                cfg_clks_per_us = PRE_W'(c);
                set_alarm(1'b1);
                wait_n(5);
                set_alarm(1'b0);
                wait_n(2 + hc);
                check($sformatf("R9 still held h=%0d c=%0d", h, c), throttle_req, 1);
                wait_n(1);
                check($sformatf("R9 released h=%0d c=%0d", h, c), throttle_req, 0);
            end
        end

        // R10: re-assertion during HOLD
        cfg_hold_us = 4'd3;
        cfg_clks_per_us = 4'd3;
        set_alarm(1'b1);
        wait_n(5);
        set_alarm(1'b0);
        wait_n(6);
        set_alarm(1'b1);
        wait_n(20);
        check("R10 held while alarm back", throttle_req, 1);
        set_alarm(1'b0);
        wait_n(2 + 9);
        check("R10 full hold restarted", throttle_req, 1);
        wait_n(1);
        check("R10 release after restart", throttle_req, 0);
        cfg_hold_us = '0;

        // R4: threshold sweep
        for (int t = 0; t < 6; t++) begin
            int need;
            need = (t == 0) ? 1 : t;
            cfg_irq_thresh = CNT_W'(t);
            cfg_irq_en = 1'b1;
            do_reset();
            for (int k = 1; k <= 6; k++) begin
                pulse();
                check($sformatf("R4 count t=%0d k=%0d", t, k), event_count, k);
                check($sformatf("R4 irq t=%0d k=%0d", t, k), irq, (k >= need) ? 1 : 0);
            end
        end

        // R6: clear keeps count; collision with event sets
        irq_clear = 1'b1;
        wait_n(1);
        irq_clear = 1'b0;
        check("R6 irq cleared", irq, 0);
        check("R6 count kept", event_count, 6);
        wait_n(3);
        check("R6 stays clear", irq, 0);
        set_alarm(1'b1);
        wait_n(2);
        irq_clear = 1'b1;
        wait_n(1);
        irq_clear = 1'b0;
        check("R6 set wins over clear", irq, 1);
        set_alarm(1'b0);
        wait_n(3);

        // R5: disabled interrupt
        cfg_irq_en = 1'b0;
        cfg_irq_thresh = '0;
        do_reset();
        for (int k = 0; k < 5; k++) pulse();
        check("R5 irq disabled", irq, 0);
        check("R5 count runs", event_count, 5);

        // R3: saturation
        for (int k = 0; k < 15; k++) pulse();
        check("R3 saturated", event_count, 15);

        // R7: quiet filter boundaries
        for (int q = 1; q <= 4; q++) begin
            cfg_quiet_clks = FILT_W'(q);
            do_reset();
            set_alarm(1'b1);
            wait_n(4);
            set_alarm(1'b0);
            wait_n(q + 1);
            check($sformatf("R7 kept q=%0d", q), event_count, 1);
            wait_n(1);
            check($sformatf("R7 cleared q=%0d", q), event_count, 0);
        end
        cfg_quiet_clks = 8'd6;
        do_reset();
        pulse();
        pulse();
        check("R7 restart by new event", event_count, 2);
        cfg_quiet_clks = '0;
        do_reset();
        pulse();
        wait_n(300);
        check("R7 zero disables clear", event_count, 1);

        // R1: active-low polarity
        cfg_active_low = 1'b1;
        do_reset();
        check("R1 idle high no alarm", throttle_req, 0);
        alarm_pin = 1'b0;
        wait_n(3);
        check("R1 low pin is alarm", event_count, 1);
        check("R1 low pin throttles", throttle_req, 1);
        alarm_pin = 1'b1;
        wait_n(5);
        check("R1 high pin idle", throttle_req, 0);
        check("R1 high pin not counted", event_count, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule